// File: doc/BRIEF.md
# Coherence Execute-Stage Update Decision Unit

This block is the execute stage of a private-cache coherence controller. The stage before it delivers three things. The first is the set-indexed contents of every way: tag, read and write privilege, and stable coherence state. The second is the least-recently-used way for that set. The third is the miss-table lookup result: whether an entry exists for the request, its index, and a free slot. A protocol table outside the block decodes the action for the request and supplies it. From these inputs the block finishes the tag match and decides whether a victim must be evicted. It then chooses the command and target way for the data cache, the write into the coherence-state array, the write into the miss table, and whether block data goes to the outgoing message stage.

A way counts as a hit only when its tag matches and it holds at least one of the two privileges. An eviction is needed when the protocol asks to place a new block, the request missed, and the least-recently-used way holds a live block. In that case the miss-table write becomes a pre-allocation. It carries the victim's block address and state and is flagged as waiting for eviction, so the issue stage can later launch the eviction ahead of other traffic to that block. Every result is registered once at the stage boundary. Each update interface carries its own valid bit.

Top module: `coh_exec_update`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, every valid output (`hit_o`, `dc_valid_o`, `cs_wen_o`, `mt_wen_o`, `fwd_valid_o`) is 0.
- R2: A way hits when its tag equals the request tag and its read or write privilege is set. `hit_o` is the request valid ANDed with the OR of all way hits. On a hit, `hit_way_o` gives the index of the hitting way.
- R3: An eviction is required when the request asks to write data on cache, no way hits, and the least-recently-used way has read or write privilege. It is signalled as data-cache command code 2.
- R4: The data-cache command is 2 (evict) when an eviction is required. Otherwise it is 1 (write privileges and data) when data is written. Otherwise it is 0 (privileges only).
- R5: The data-cache way and the coherence-state way are both the hit way on a hit, and the least-recently-used way on a miss.
- R6: `dc_valid_o` is set when the request is valid and either privileges are updated on a hit or data is written on cache.
- R7: `cs_wen_o` is set when the request is valid, the next state is stable, and the request either hit or writes data. The write carries the request set index and the next state.
- R8: `mt_wen_o` is set when the request is valid and the action allocates, updates or deallocates an entry. `mt_idx_o` is the looked-up index when the miss table hit, and the free index otherwise.
- R9: When an eviction is required, the miss-table write carries the following: address {victim tag, request set, all-zero offset}, the victim way's coherence state, waiting-for-eviction = 1, and entry-valid = 1.
- R10: Without an eviction, the miss-table write carries the following: the full request address, the next state, waiting-for-eviction = 0, and entry-valid = the inverse of the deallocate action.
- R11: `fwd_valid_o` is set when the request is valid and the action sends data from cache. It carries the request set and the hit way.
- R12: All outputs are registered: each reflects the inputs of the previous clock. A cycle with request valid low yields all valid outputs low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present in this stage |
| req_tag_i | input | TAG_W | Request tag |
| req_set_i | input | SET_W | Request set index |
| req_ofs_i | input | OFS_W | Request block offset |
| way_tag_i | input | WAYS*TAG_W | Per-way tags, way 0 in the low bits |
| way_rd_i | input | WAYS | Per-way read privilege |
| way_wr_i | input | WAYS | Per-way write privilege |
| way_state_i | input | WAYS*ST_W | Per-way stable coherence state |
| lru_way_i | input | WIDX_W | Least-recently-used way of the set |
| mt_hit_i | input | 1 | Miss-table entry exists for the request |
| mt_hit_idx_i | input | MT_IDX_W | Index of that entry |
| mt_free_idx_i | input | MT_IDX_W | Index of a free entry |
| act_wr_data_i | input | 1 | Action: write block data on cache |
| act_upd_priv_i | input | 1 | Action: update privileges |
| act_next_state_i | input | ST_W | Action: next coherence state |
| act_next_stable_i | input | 1 | Action: next state is stable |
| act_alloc_i | input | 1 | Action: allocate miss-table entry |
| act_update_i | input | 1 | Action: update miss-table entry |
| act_dealloc_i | input | 1 | Action: deallocate miss-table entry |
| act_send_data_i | input | 1 | Action: send cache data to message stage |
| hit_o | output | 1 | Registered request hit |
| hit_way_o | output | WIDX_W | Registered hit way index |
| dc_valid_o | output | 1 | Data-cache update valid |
| dc_cmd_o | output | 2 | Data-cache command (0 privileges, 1 privileges and data, 2 evict) |
| dc_way_o | output | WIDX_W | Data-cache target way |
| cs_wen_o | output | 1 | Coherence-state write enable |
| cs_set_o | output | SET_W | Coherence-state set index |
| cs_way_o | output | WIDX_W | Coherence-state way |
| cs_state_o | output | ST_W | Coherence state to write |
| mt_wen_o | output | 1 | Miss-table write enable |
| mt_idx_o | output | MT_IDX_W | Miss-table entry index |
| mt_addr_o | output | TAG_W+SET_W+OFS_W | Entry address {tag, set, offset} |
| mt_state_o | output | ST_W | Entry coherence state |
| mt_wait_evict_o | output | 1 | Entry is an eviction pre-allocation |
| mt_entry_valid_o | output | 1 | Entry valid bit to store |
| fwd_valid_o | output | 1 | Send cache data to message stage |
| fwd_set_o | output | SET_W | Set of the data to send |
| fwd_way_o | output | WIDX_W | Way of the data to send |

## Verification
Every result of this stage comes from one register between its inputs and its outputs, so each is due exactly one rising edge after the stimulus that causes it. The bench applies each vector on a falling edge and holds it for a full period. It compares the outputs on the following falling edge, after the single capture edge and before the next vector goes in. Payload fields are compared only in cycles where their valid bit is expected high. The sweep covers every combination of the seven action bits against hit, miss, decoy and victim-liveness scenarios.

// File: rtl/coh_exec_pkg.sv
package coh_exec_pkg;

  typedef enum logic [1:0] {
    DC_CMD_PRIV      = 2'd0,
    DC_CMD_PRIV_DATA = 2'd1,
    DC_CMD_EVICT     = 2'd2
  } dc_cmd_e;

endpackage

// File: rtl/coh_tag_match.sv
module coh_tag_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 4,
  parameter int WIDX_W = 2
) (
  input  logic [WAYS*TAG_W-1:0] way_tag_i,
  input  logic [WAYS-1:0]       way_rd_i,
  input  logic [WAYS-1:0]       way_wr_i,
  input  logic [TAG_W-1:0]      req_tag_i,
  output logic                  hit_o,
  output logic [WIDX_W-1:0]     hit_idx_o
);

  logic [WAYS-1:0] match_oh;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match_oh[w] = (way_tag_i[w*TAG_W +: TAG_W] == req_tag_i) &&
                         (way_rd_i[w] || way_wr_i[w]);
  end

  assign hit_o = |match_oh;

  always_comb begin
    hit_idx_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_oh[w]) hit_idx_o = hit_idx_o | WIDX_W'(w);
    end
  end

endmodule

// File: rtl/coh_victim_sel.sv
module coh_victim_sel #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 4,
  parameter int ST_W   = 2,
  parameter int WIDX_W = 2
) (
  input  logic [WAYS*TAG_W-1:0] way_tag_i,
  input  logic [WAYS-1:0]       way_rd_i,
  input  logic [WAYS-1:0]       way_wr_i,
  input  logic [WAYS*ST_W-1:0]  way_state_i,
  input  logic [WIDX_W-1:0]     lru_way_i,
  input  logic                  hit_i,
  input  logic                  wr_data_i,
  output logic                  evict_o,
  output logic [TAG_W-1:0]      vic_tag_o,
  output logic [ST_W-1:0]       vic_state_o
);

  logic [TAG_W-1:0] tag_a   [WAYS];
  logic [ST_W-1:0]  state_a [WAYS];
  logic             live_a  [WAYS];
  logic             vic_live;

  for (genvar w = 0; w < WAYS; w++) begin : g_unpack
    assign tag_a[w]   = way_tag_i[w*TAG_W +: TAG_W];
    assign state_a[w] = way_state_i[w*ST_W +: ST_W];
    assign live_a[w]  = way_rd_i[w] | way_wr_i[w];
  end

  assign vic_live    = live_a[lru_way_i];
  assign vic_tag_o   = tag_a[lru_way_i];
  assign vic_state_o = state_a[lru_way_i];
  assign evict_o     = wr_data_i && !hit_i && vic_live;

endmodule

// File: rtl/coh_update_route.sv
module coh_update_route
  import coh_exec_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int SET_W    = 3,
  parameter int OFS_W    = 2,
  parameter int ST_W     = 2,
  parameter int WIDX_W   = 2,
  parameter int MT_IDX_W = 2,
  parameter int ADDR_W   = TAG_W + SET_W + OFS_W
) (
  input  logic                req_valid_i,
  input  logic [TAG_W-1:0]    req_tag_i,
  input  logic [SET_W-1:0]    req_set_i,
  input  logic [OFS_W-1:0]    req_ofs_i,
  input  logic                hit_i,
  input  logic [WIDX_W-1:0]   hit_idx_i,
  input  logic [WIDX_W-1:0]   lru_way_i,
  input  logic                evict_i,
  input  logic [TAG_W-1:0]    vic_tag_i,
  input  logic [ST_W-1:0]     vic_state_i,
  input  logic                mt_hit_i,
  input  logic [MT_IDX_W-1:0] mt_hit_idx_i,
  input  logic [MT_IDX_W-1:0] mt_free_idx_i,
  input  logic                act_wr_data_i,
  input  logic                act_upd_priv_i,
  input  logic [ST_W-1:0]     act_next_state_i,
  input  logic                act_next_stable_i,
  input  logic                act_alloc_i,
  input  logic                act_update_i,
  input  logic                act_dealloc_i,
  input  logic                act_send_data_i,
  output logic                dc_valid_o,
  output dc_cmd_e             dc_cmd_o,
  output logic [WIDX_W-1:0]   tgt_way_o,
  output logic                cs_wen_o,
  output logic                mt_wen_o,
  output logic [MT_IDX_W-1:0] mt_idx_o,
  output logic [ADDR_W-1:0]   mt_addr_o,
  output logic [ST_W-1:0]     mt_state_o,
  output logic                mt_wait_evict_o,
  output logic                mt_entry_valid_o,
  output logic                fwd_valid_o
);

  always_comb begin
    if (evict_i)            dc_cmd_o = DC_CMD_EVICT;
    else if (act_wr_data_i) dc_cmd_o = DC_CMD_PRIV_DATA;
    else                    dc_cmd_o = DC_CMD_PRIV;
  end

  assign tgt_way_o  = hit_i ? hit_idx_i : lru_way_i;
  assign dc_valid_o = req_valid_i && ((act_upd_priv_i && hit_i) || act_wr_data_i);
  assign cs_wen_o   = req_valid_i && act_next_stable_i && (hit_i || act_wr_data_i);
  assign mt_wen_o   = req_valid_i && (act_alloc_i || act_update_i || act_dealloc_i);
  assign mt_idx_o   = mt_hit_i ? mt_hit_idx_i : mt_free_idx_i;

  always_comb begin
    if (evict_i) begin
      mt_addr_o        = {vic_tag_i, req_set_i, {OFS_W{1'b0}}};
      mt_state_o       = vic_state_i;
      mt_wait_evict_o  = 1'b1;
      mt_entry_valid_o = 1'b1;
    end else begin
      mt_addr_o        = {req_tag_i, req_set_i, req_ofs_i};
      mt_state_o       = act_next_state_i;
      mt_wait_evict_o  = 1'b0;
      mt_entry_valid_o = !act_dealloc_i;
    end
  end

  assign fwd_valid_o = req_valid_i && act_send_data_i;

endmodule

// File: rtl/coh_exec_update.sv
module coh_exec_update
  import coh_exec_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int TAG_W      = 4,
  parameter int SET_W      = 3,
  parameter int OFS_W      = 2,
  parameter int ST_W       = 2,
  parameter int MT_ENTRIES = 4,
  parameter int WIDX_W     = $clog2(WAYS),
  parameter int MT_IDX_W   = $clog2(MT_ENTRIES),
  parameter int ADDR_W     = TAG_W + SET_W + OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic [SET_W-1:0]      req_set_i,
  input  logic [OFS_W-1:0]      req_ofs_i,
  input  logic [WAYS*TAG_W-1:0] way_tag_i,
  input  logic [WAYS-1:0]       way_rd_i,
  input  logic [WAYS-1:0]       way_wr_i,
  input  logic [WAYS*ST_W-1:0]  way_state_i,
  input  logic [WIDX_W-1:0]     lru_way_i,
  input  logic                  mt_hit_i,
  input  logic [MT_IDX_W-1:0]   mt_hit_idx_i,
  input  logic [MT_IDX_W-1:0]   mt_free_idx_i,
  input  logic                  act_wr_data_i,
  input  logic                  act_upd_priv_i,
  input  logic [ST_W-1:0]       act_next_state_i,
  input  logic                  act_next_stable_i,
  input  logic                  act_alloc_i,
  input  logic                  act_update_i,
  input  logic                  act_dealloc_i,
  input  logic                  act_send_data_i,
  output logic                  hit_o,
  output logic [WIDX_W-1:0]     hit_way_o,
  output logic                  dc_valid_o,
  output logic [1:0]            dc_cmd_o,
  output logic [WIDX_W-1:0]     dc_way_o,
  output logic                  cs_wen_o,
  output logic [SET_W-1:0]      cs_set_o,
  output logic [WIDX_W-1:0]     cs_way_o,
  output logic [ST_W-1:0]       cs_state_o,
  output logic                  mt_wen_o,
  output logic [MT_IDX_W-1:0]   mt_idx_o,
  output logic [ADDR_W-1:0]     mt_addr_o,
  output logic [ST_W-1:0]       mt_state_o,
  output logic                  mt_wait_evict_o,
  output logic                  mt_entry_valid_o,
  output logic                  fwd_valid_o,
  output logic [SET_W-1:0]      fwd_set_o,
  output logic [WIDX_W-1:0]     fwd_way_o
);

  // ---- next-state logic ----
  logic                hit_c;
  logic [WIDX_W-1:0]   hit_idx_c;
  logic                evict_c;
  logic [TAG_W-1:0]    vic_tag_c;
  logic [ST_W-1:0]     vic_state_c;
  logic                dc_valid_c;
  dc_cmd_e             dc_cmd_c;
  logic [WIDX_W-1:0]   tgt_way_c;
  logic                cs_wen_c;
  logic                mt_wen_c;
  logic [MT_IDX_W-1:0] mt_idx_c;
  logic [ADDR_W-1:0]   mt_addr_c;
  logic [ST_W-1:0]     mt_state_c;
  logic                mt_wait_c;
  logic                mt_ev_c;
  logic                fwd_valid_c;

  coh_tag_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .WIDX_W(WIDX_W)
  ) u_match (
    .way_tag_i (way_tag_i),
    .way_rd_i  (way_rd_i),
    .way_wr_i  (way_wr_i),
    .req_tag_i (req_tag_i),
    .hit_o     (hit_c),
    .hit_idx_o (hit_idx_c)
  );

  coh_victim_sel #(
    .WAYS(WAYS), .TAG_W(TAG_W), .ST_W(ST_W), .WIDX_W(WIDX_W)
  ) u_victim (
    .way_tag_i   (way_tag_i),
    .way_rd_i    (way_rd_i),
    .way_wr_i    (way_wr_i),
    .way_state_i (way_state_i),
    .lru_way_i   (lru_way_i),
    .hit_i       (hit_c),
    .wr_data_i   (act_wr_data_i),
    .evict_o     (evict_c),
    .vic_tag_o   (vic_tag_c),
    .vic_state_o (vic_state_c)
  );

  coh_update_route #(
    .TAG_W(TAG_W), .SET_W(SET_W), .OFS_W(OFS_W), .ST_W(ST_W),
    .WIDX_W(WIDX_W), .MT_IDX_W(MT_IDX_W), .ADDR_W(ADDR_W)
  ) u_route (
    .req_valid_i       (req_valid_i),
    .req_tag_i         (req_tag_i),
    .req_set_i         (req_set_i),
    .req_ofs_i         (req_ofs_i),
    .hit_i             (hit_c),
    .hit_idx_i         (hit_idx_c),
    .lru_way_i         (lru_way_i),
    .evict_i           (evict_c),
    .vic_tag_i         (vic_tag_c),
    .vic_state_i       (vic_state_c),
    .mt_hit_i          (mt_hit_i),
    .mt_hit_idx_i      (mt_hit_idx_i),
    .mt_free_idx_i     (mt_free_idx_i),
    .act_wr_data_i     (act_wr_data_i),
    .act_upd_priv_i    (act_upd_priv_i),
    .act_next_state_i  (act_next_state_i),
    .act_next_stable_i (act_next_stable_i),
    .act_alloc_i       (act_alloc_i),
    .act_update_i      (act_update_i),
    .act_dealloc_i     (act_dealloc_i),
    .act_send_data_i   (act_send_data_i),
    .dc_valid_o        (dc_valid_c),
    .dc_cmd_o          (dc_cmd_c),
    .tgt_way_o         (tgt_way_c),
    .cs_wen_o          (cs_wen_c),
    .mt_wen_o          (mt_wen_c),
    .mt_idx_o          (mt_idx_c),
    .mt_addr_o         (mt_addr_c),
    .mt_state_o        (mt_state_c),
    .mt_wait_evict_o   (mt_wait_c),
    .mt_entry_valid_o  (mt_ev_c),
    .fwd_valid_o       (fwd_valid_c)
  );

  // ---- stage register ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o            <= 1'b0;
      hit_way_o        <= '0;
      dc_valid_o       <= 1'b0;
      dc_cmd_o         <= '0;
      dc_way_o         <= '0;
      cs_wen_o         <= 1'b0;
      cs_set_o         <= '0;
      cs_way_o         <= '0;
      cs_state_o       <= '0;
      mt_wen_o         <= 1'b0;
      mt_idx_o         <= '0;
      mt_addr_o        <= '0;
      mt_state_o       <= '0;
      mt_wait_evict_o  <= 1'b0;
      mt_entry_valid_o <= 1'b0;
      fwd_valid_o      <= 1'b0;
      fwd_set_o        <= '0;
      fwd_way_o        <= '0;
    end else begin
      hit_o            <= req_valid_i && hit_c;
      hit_way_o        <= hit_idx_c;
      dc_valid_o       <= dc_valid_c;
      dc_cmd_o         <= dc_cmd_c;
      dc_way_o         <= tgt_way_c;
      cs_wen_o         <= cs_wen_c;
      cs_set_o         <= req_set_i;
      cs_way_o         <= tgt_way_c;
      cs_state_o       <= act_next_state_i;
      mt_wen_o         <= mt_wen_c;
      mt_idx_o         <= mt_idx_c;
      mt_addr_o        <= mt_addr_c;
      mt_state_o       <= mt_state_c;
      mt_wait_evict_o  <= mt_wait_c;
      mt_entry_valid_o <= mt_ev_c;
      fwd_valid_o      <= fwd_valid_c;
      fwd_set_o        <= req_set_i;
      fwd_way_o        <= hit_idx_c;
    end
  end

endmodule

// File: rtl/coh_exec_update_chk.sv
module coh_exec_update_chk #(
  parameter int WIDX_W   = 2,
  parameter int MT_IDX_W = 2,
  parameter int OFS_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid_i,
  input logic                act_wr_data_i,
  input logic                act_upd_priv_i,
  input logic                act_next_stable_i,
  input logic                mt_hit_i,
  input logic [MT_IDX_W-1:0] mt_hit_idx_i,
  input logic [MT_IDX_W-1:0] mt_free_idx_i,
  input logic                hit_o,
  input logic [WIDX_W-1:0]   hit_way_o,
  input logic                dc_valid_o,
  input logic [1:0]          dc_cmd_o,
  input logic                cs_wen_o,
  input logic                mt_wen_o,
  input logic [MT_IDX_W-1:0] mt_idx_o,
  input logic [OFS_W+1:0]    mt_addr_o,
  input logic                mt_wait_evict_o,
  input logic                fwd_valid_o,
  input logic [WIDX_W-1:0]   fwd_way_o
);

  assert_evict_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_valid_o && dc_cmd_o == 2'd2) |-> (!hit_o && $past(act_wr_data_i)));

  assert_dc_valid_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dc_valid_o |-> ($past(act_wr_data_i) || (hit_o && $past(act_upd_priv_i))));

  assert_cs_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wen_o |-> $past(act_next_stable_i && req_valid_i));

  assert_mt_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mt_wen_o |-> (mt_idx_o == ($past(mt_hit_i) ? $past(mt_hit_idx_i) : $past(mt_free_idx_i))));

  assert_evict_offset_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_wen_o && mt_wait_evict_o) |-> (mt_addr_o[OFS_W-1:0] == '0));

  assert_fwd_hit_way_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o |-> (fwd_way_o == hit_way_o));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid_i) |-> !(hit_o || dc_valid_o || cs_wen_o || mt_wen_o || fwd_valid_o));

endmodule

bind coh_exec_update coh_exec_update_chk #(
  .WIDX_W(WIDX_W), .MT_IDX_W(MT_IDX_W), .OFS_W(OFS_W)
) chk_i (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_valid_i       (req_valid_i),
  .act_wr_data_i     (act_wr_data_i),
  .act_upd_priv_i    (act_upd_priv_i),
  .act_next_stable_i (act_next_stable_i),
  .mt_hit_i          (mt_hit_i),
  .mt_hit_idx_i      (mt_hit_idx_i),
  .mt_free_idx_i     (mt_free_idx_i),
  .hit_o             (hit_o),
  .hit_way_o         (hit_way_o),
  .dc_valid_o        (dc_valid_o),
  .dc_cmd_o          (dc_cmd_o),
  .cs_wen_o          (cs_wen_o),
  .mt_wen_o          (mt_wen_o),
  .mt_idx_o          (mt_idx_o),
  .mt_addr_o         (mt_addr_o[OFS_W+1:0]),
  .mt_wait_evict_o   (mt_wait_evict_o),
  .fwd_valid_o       (fwd_valid_o),
  .fwd_way_o         (fwd_way_o)
);

// File: tb/coh_exec_update_tb_top.sv
module coh_exec_update_tb_top;

  localparam int WAYS = 4, TAG_W = 4, SET_W = 3, OFS_W = 2, ST_W = 2, MT_ENTRIES = 4;
  localparam int WIDX_W = $clog2(WAYS), MT_IDX_W = $clog2(MT_ENTRIES);
  localparam int ADDR_W = TAG_W + SET_W + OFS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                  req_valid;
  logic [TAG_W-1:0]      req_tag;
  logic [SET_W-1:0]      req_set;
  logic [OFS_W-1:0]      req_ofs;
  logic [TAG_W-1:0]      tg [WAYS];
  logic [ST_W-1:0]       st [WAYS];
  logic [WAYS*TAG_W-1:0] way_tag;
  logic [WAYS*ST_W-1:0]  way_state;
  logic [WAYS-1:0]       way_rd, way_wr;
  logic [WIDX_W-1:0]     lru;
  logic                  mt_hit;
  logic [MT_IDX_W-1:0]   mt_hidx, mt_free;
  logic                  a_wr, a_priv, a_stable, a_alloc, a_upd, a_dealloc, a_send;
  logic [ST_W-1:0]       a_next;

  logic                  hit_o;
  logic [WIDX_W-1:0]     hit_way_o, dc_way_o, cs_way_o, fwd_way_o;
  logic                  dc_valid_o, cs_wen_o, mt_wen_o, mt_wait_o, mt_ev_o, fwd_valid_o;
  logic [1:0]            dc_cmd_o;
  logic [SET_W-1:0]      cs_set_o, fwd_set_o;
  logic [ST_W-1:0]       cs_state_o, mt_state_o;
  logic [MT_IDX_W-1:0]   mt_idx_o;
  logic [ADDR_W-1:0]     mt_addr_o;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      way_tag[w*TAG_W +: TAG_W] = tg[w];
      way_state[w*ST_W +: ST_W] = st[w];
    end
  end

  coh_exec_update #(
    .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .OFS_W(OFS_W),
    .ST_W(ST_W), .MT_ENTRIES(MT_ENTRIES)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_tag_i(req_tag),
    .req_set_i(req_set), .req_ofs_i(req_ofs), .way_tag_i(way_tag),
    .way_rd_i(way_rd), .way_wr_i(way_wr), .way_state_i(way_state),
    .lru_way_i(lru), .mt_hit_i(mt_hit), .mt_hit_idx_i(mt_hidx),
    .mt_free_idx_i(mt_free), .act_wr_data_i(a_wr), .act_upd_priv_i(a_priv),
    .act_next_state_i(a_next), .act_next_stable_i(a_stable),
    .act_alloc_i(a_alloc), .act_update_i(a_upd), .act_dealloc_i(a_dealloc),
    .act_send_data_i(a_send), .hit_o(hit_o), .hit_way_o(hit_way_o),
    .dc_valid_o(dc_valid_o), .dc_cmd_o(dc_cmd_o), .dc_way_o(dc_way_o),
    .cs_wen_o(cs_wen_o), .cs_set_o(cs_set_o), .cs_way_o(cs_way_o),
    .cs_state_o(cs_state_o), .mt_wen_o(mt_wen_o), .mt_idx_o(mt_idx_o),
    .mt_addr_o(mt_addr_o), .mt_state_o(mt_state_o),
    .mt_wait_evict_o(mt_wait_o), .mt_entry_valid_o(mt_ev_o),
    .fwd_valid_o(fwd_valid_o), .fwd_set_o(fwd_set_o), .fwd_way_o(fwd_way_o)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_tag = '0; req_set = '0; req_ofs = '0;
    for (int w = 0; w < WAYS; w++) begin tg[w] = '0; st[w] = '0; end
    way_rd = '0; way_wr = '0; lru = '0; mt_hit = 0; mt_hidx = '0; mt_free = '0;
    a_wr = 0; a_priv = 0; a_stable = 0; a_alloc = 0; a_upd = 0; a_dealloc = 0;
    a_send = 0; a_next = '0;
  endtask

  // expected values from the requirements
  task automatic check_outputs();
    logic ehit; logic [WIDX_W-1:0] eway, etgt; logic vlive, ev;
    logic [1:0] ecmd; logic edc, ecs, emt, efwd;
    logic [ADDR_W-1:0] eaddr; logic [ST_W-1:0] est; logic ewait, eev;
    ehit = 0; eway = '0;
    for (int w = 0; w < WAYS; w++)
      if (tg[w] == req_tag && (way_rd[w] || way_wr[w])) begin ehit = 1; eway = WIDX_W'(w); end
    vlive = way_rd[lru] || way_wr[lru];
    ev    = a_wr && !ehit && vlive;
    ecmd  = ev ? 2'd2 : (a_wr ? 2'd1 : 2'd0);
    etgt  = ehit ? eway : lru;
    edc   = req_valid && ((a_priv && ehit) || a_wr);
    ecs   = req_valid && a_stable && (ehit || a_wr);
    emt   = req_valid && (a_alloc || a_upd || a_dealloc);
    efwd  = req_valid && a_send;
    if (ev) begin
      eaddr = {tg[lru], req_set, {OFS_W{1'b0}}}; est = st[lru]; ewait = 1; eev = 1;
    end else begin
      eaddr = {req_tag, req_set, req_ofs}; est = a_next; ewait = 0; eev = !a_dealloc;
    end
    @(negedge clk);
    if (!req_valid) begin
      chk("R12 idle valids", {27'd0, hit_o, dc_valid_o, cs_wen_o, mt_wen_o, fwd_valid_o}, 32'd0);
      return;
    end
    chk("R2 hit", 32'(hit_o), 32'(ehit));
    if (ehit) chk("R2 hit way", 32'(hit_way_o), 32'(eway));
    chk("R6 dc valid", 32'(dc_valid_o), 32'(edc));
    if (edc) begin
      chk(ev ? "R3 evict cmd" : "R4 dc cmd", 32'(dc_cmd_o), 32'(ecmd));
      chk("R5 dc way", 32'(dc_way_o), 32'(etgt));
    end
    chk("R7 cs wen", 32'(cs_wen_o), 32'(ecs));
    if (ecs) begin
      chk("R7 cs set", 32'(cs_set_o), 32'(req_set));
      chk("R7 cs state", 32'(cs_state_o), 32'(a_next));
      chk("R5 cs way", 32'(cs_way_o), 32'(etgt));
    end
    chk("R8 mt wen", 32'(mt_wen_o), 32'(emt));
    if (emt) begin
      chk("R8 mt idx", 32'(mt_idx_o), 32'(mt_hit ? mt_hidx : mt_free));
      chk(ev ? "R9 mt addr" : "R10 mt addr", 32'(mt_addr_o), 32'(eaddr));
      chk(ev ? "R9 mt state" : "R10 mt state", 32'(mt_state_o), 32'(est));
      chk(ev ? "R9 mt wait" : "R10 mt wait", 32'(mt_wait_o), 32'(ewait));
      chk(ev ? "R9 mt entry valid" : "R10 mt entry valid", 32'(mt_ev_o), 32'(eev));
    end
    chk("R11 fwd valid", 32'(fwd_valid_o), 32'(efwd));
    if (efwd) begin
      chk("R11 fwd set", 32'(fwd_set_o), 32'(req_set));
      chk("R11 fwd way", 32'(fwd_way_o), 32'(eway));
    end
  endtask

  // scen: 0..4 picks the matching way (4 = none); bit of decoy; victim liveness
  task automatic apply_vec(input int act, input int match, input int lru_sel,
                           input bit vic_live, input bit decoy);
    logic [31:0] r;
    r = rnd();
    req_valid = (r[2:0] != 3'd0);
    req_tag = TAG_W'(rnd()); req_set = SET_W'(rnd()); req_ofs = OFS_W'(rnd());
    lru = WIDX_W'(lru_sel);
    for (int w = 0; w < WAYS; w++) begin
      r = rnd();
      tg[w] = req_tag ^ TAG_W'(w + 1);
      st[w] = ST_W'(r[9:8]);
      way_rd[w] = r[0];
      way_wr[w] = r[1];
      if (w == match) begin
        tg[w] = req_tag;
        if (!(r[0] || r[1])) way_wr[w] = 1'b1;
      end
    end
    if (decoy && match != 0) begin
      tg[0] = req_tag; way_rd[0] = 0; way_wr[0] = 0;
    end
    if (lru_sel != match) begin
      way_rd[lru_sel] = vic_live && r[4];
      way_wr[lru_sel] = vic_live && !r[4];
      if (decoy && lru_sel == 0 && match != 0) begin way_rd[0] = 0; way_wr[0] = 0; end
    end
    r = rnd();
    mt_hit = r[0]; mt_hidx = MT_IDX_W'(r[3:2]); mt_free = MT_IDX_W'(r[5:4]);
    a_next = ST_W'(r[7:6]);
    {a_wr, a_priv, a_stable, a_alloc, a_upd, a_dealloc, a_send} = 7'(act);
    check_outputs();
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 reset valids", {27'd0, hit_o, dc_valid_o, cs_wen_o, mt_wen_o, fwd_valid_o}, 32'd0);
    // inputs driven active during reset must not show after release
    req_valid = 1; a_wr = 1; a_send = 1; a_alloc = 1; a_stable = 1;
    @(negedge clk);
    chk("R1 reset held", {27'd0, hit_o, dc_valid_o, cs_wen_o, mt_wen_o, fwd_valid_o}, 32'd0);
    idle_inputs();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post release", {27'd0, hit_o, dc_valid_o, cs_wen_o, mt_wen_o, fwd_valid_o}, 32'd0);

    // directed: eviction with nonzero request offset, victim way 2
    idle_inputs();
    req_valid = 1; req_tag = 4'h5; req_set = 3'h6; req_ofs = 2'h3;
    for (int w = 0; w < WAYS; w++) tg[w] = 4'hA + TAG_W'(w);
    st[2] = 2'h3; way_rd = 4'b0100; lru = 2'd2; a_wr = 1; a_alloc = 1;
    mt_free = 2'd1;
    check_outputs();
    chk("R9 directed victim addr", 32'(mt_addr_o), 32'({4'hC, 3'h6, 2'h0}));

    // exhaustive action bits across scenarios
    for (int act = 0; act < 128; act++)
      for (int match = 0; match <= WAYS; match++)
        for (int l = 0; l < WAYS; l++)
          for (int v = 0; v < 2; v++)
            apply_vec(act, match, l, v[0], act[0] ^ v[0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule